// File: doc/BRIEF.md
# Change-Triggered Status Interrupt Controller

This block watches a wide vector of live status inputs produced elsewhere in a video front end: field-rate detection, capture readiness, a two-bit detected colour standard, copy-protection levels, caption and line-signalling identification, and a scaler output error. Any change of a status bit, rising or falling, is a trigger. A trigger on a bit whose enable mask bit is set marks that bit pending. The status bits are grouped into banks of eight, and each bank has a parallel set of eight pending flags.

A host reaches the block through a read port with a one-cycle strobe and a bank index. A read returns the present live status of the chosen bank in the same cycle, not a snapshot taken when the interrupt was raised. The strobe clears every pending flag of that bank at the next clock edge. Flags in other banks stay set. A trigger arriving on the same edge as the clearing read keeps its flag set. The level interrupt output is registered. It is high while any pending flag has its mask bit set.

Top module: `sic_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_o` is 0 and no flag is pending.
- R2: With `rd_stb_i` high, `rd_data_o` equals status bits [8k+7:8k] for `rd_idx_i` = k in the same cycle, reflecting the live inputs.
- R3: A change of a status bit in either direction sampled at a clock edge, with its mask bit set, makes that bit pending from that edge on.
- R4: The first status value sampled after reset is taken as the baseline and raises no trigger.
- R5: A read strobe with index k clears all pending flags of bank k at the next edge and leaves flags of every other bank unchanged.
- R6: A trigger on the same edge as the clearing read of its bank leaves that flag pending.
- R7: A mask bit of 0 keeps a trigger from setting its flag, does not clear a flag already pending, and keeps that flag from driving `irq_o` until the mask bit returns to 1.
- R8: `irq_o` is registered: after each edge it equals the OR of the pending flags ANDed with the mask sampled at that edge.
- R9: A multi-bit field such as the two-bit colour-standard code raises a trigger on any change of value, including a change to 00 (colour lost).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 32 | Live status, bank k at bits [8k+7:8k] |
| mask_i | input | 32 | Enable mask, one bit per status bit |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_idx_i | input | 2 | Bank index of the read |
| rd_data_o | output | 8 | Live status of the addressed bank |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after a trigger that lands on the same edge as the clearing read. A design that lets the clear win loses that event, and `irq_o` falls when it should stay high. It reads banks other than the pending one to catch a clear that is decoded too broadly. It also toggles bits downward and drives a two-bit field to 00, which exposes a detector that only reacts to rising edges. Masking and then unmasking a pending flag shows whether the mask wrongly clears state. Status that is already non-zero when reset is released shows whether the design raises a false interrupt at start-up.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned SIC_REG_W    = 8;
  localparam int unsigned SIC_NUM_REGS = 4;

  // baseline state of a change detector
  typedef enum logic {
    ARM_WAIT = 1'b0,
    ARM_LIVE = 1'b1
  } sic_arm_e;
endpackage

// File: rtl/sic_change_det.sv
module sic_change_det
  import sic_pkg::*;
#(
  parameter int unsigned W = SIC_REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  sic_arm_e     arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      arm_q  <= ARM_WAIT;
    end else begin
      prev_q <= stat_i;
      arm_q  <= ARM_LIVE;
    end
  end

  assign chg_o = (arm_q == ARM_LIVE) ? (stat_i ^ prev_q) : '0;

  // R4: no trigger from the first sample after reset
  a_r4_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chg_o == '0));
endmodule

// File: rtl/sic_pend_bank.sv
module sic_pend_bank
  import sic_pkg::*;
#(
  parameter int unsigned W = SIC_REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o,
  output logic         hit_nxt_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_nxt;
  logic [W-1:0] set_v;

  assign set_v = chg_i & mask_i;

  always_comb begin
    pend_nxt = pend_q;
    if (clr_i) pend_nxt = '0;
    pend_nxt = pend_nxt | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  assign pend_o    = pend_q;
  assign hit_nxt_o = |(pend_nxt & mask_i);

  // R3: an enabled change marks its bit pending
  a_r3_enabled_change_sets: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R5: a clear with no new trigger empties the bank
  a_r5_read_clears_bank: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (set_v == '0)) |=> (pend_q == '0));

  // R5: without a clear no flag is lost
  a_r5_no_clear_keeps: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6: a trigger on the clearing edge survives
  a_r6_set_wins_over_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (|set_v)) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R7: a flag only appears through an enabled change
  a_r7_masked_never_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_v)) == '0));
endmodule

// File: rtl/sic_irq_merge.sv
module sic_irq_merge
  import sic_pkg::*;
#(
  parameter int unsigned N = SIC_NUM_REGS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |hit_i;
  end

  assign irq_o = irq_q;

  // R1: the request is low right after reset
  a_r1_low_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);
endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int unsigned REG_W    = SIC_REG_W,
  parameter int unsigned NUM_REGS = SIC_NUM_REGS,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned TOT_W   = REG_W * NUM_REGS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOT_W-1:0] status_i,
  input  logic [TOT_W-1:0] mask_i,
  input  logic             rd_stb_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [REG_W-1:0]    stat_bank [NUM_REGS];
  logic [NUM_REGS-1:0] hit_nxt;
  logic [TOT_W-1:0]    pend_all;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
    logic [REG_W-1:0] chg;
    logic [REG_W-1:0] pend;
    logic             clr;

    assign stat_bank[k] = status_i[k*REG_W +: REG_W];
    assign clr          = rd_stb_i && (rd_idx_i == IDX_W'(k));

    sic_change_det #(.W(REG_W)) u_det (
      .clk    (clk),
      .rst    (rst),
      .stat_i (stat_bank[k]),
      .chg_o  (chg)
    );

    sic_pend_bank #(.W(REG_W)) u_pend (
      .clk       (clk),
      .rst       (rst),
      .chg_i     (chg),
      .mask_i    (mask_i[k*REG_W +: REG_W]),
      .clr_i     (clr),
      .pend_o    (pend),
      .hit_nxt_o (hit_nxt[k])
    );

    assign pend_all[k*REG_W +: REG_W] = pend;
  end

  assign rd_data_o = stat_bank[rd_idx_i];

  sic_irq_merge #(.N(NUM_REGS)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .hit_i (hit_nxt),
    .irq_o (irq_o)
  );

  // R8: the request mirrors masked pending flags one edge later
  a_r8_irq_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(pend_all & $past(mask_i))));
endmodule

// File: tb/sic_top_test.sv
`timescale 1ns/1ps
module sic_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] status = '0;
  logic [31:0] mask = '0;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_prev [32];
  bit m_pend [32];
  bit m_armed = 0;
  bit m_irq = 0;

  always #4 clk = ~clk;

  sic_top uut (
    .clk(clk), .rst(rst), .status_i(status), .mask_i(mask),
    .rd_stb_i(rd_stb), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on each edge
  always @(posedge clk) begin
    if (rst) begin
      m_armed = 0;
      m_irq = 0;
      for (int b = 0; b < 32; b++) m_pend[b] = 0;
    end else begin
      bit any;
      any = 0;
      for (int b = 0; b < 32; b++) begin
        bit trig;
        bit rd_hit;
        trig = m_armed && (status[b] != m_prev[b]);
        rd_hit = rd_stb && (int'(rd_idx) == b / 8);
        if (trig && mask[b]) m_pend[b] = 1;
        else if (rd_hit) m_pend[b] = 0;
        if (m_pend[b] && mask[b]) any = 1;
      end
      m_irq = any;
      m_armed = 1;
    end
    for (int b = 0; b < 32; b++) m_prev[b] = status[b];
  end

  // per-cycle comparison away from the edge (R8, R2)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      if (rd_stb) chk("R2 live read", {24'b0, rd_data}, {24'b0, status[int'(rd_idx)*8 +: 8]});
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic rd(input int k);
    rd_stb = 1'b1;
    rd_idx = 2'(k);
    #1;
    chk("R2 same-cycle data", {24'b0, rd_data}, {24'b0, status[k*8 +: 8]});
    tick();
    rd_stb = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    status = 32'h5A00_00C3;   // non-zero while reset is high (R4)
    mask = 32'hFFFF_FFFF;
    repeat (3) tick();
    chk("R1 irq in reset", {31'b0, irq}, 32'd0);
    rst = 1'b0;
    tick();
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);
    tick();
    chk("R4 baseline no trigger", {31'b0, irq}, 32'd0);

    // R3 rising change in bank 2
    status[19] = ~status[19];
    tick();
    chk("R3 rising change", {31'b0, irq}, 32'd1);
    rd(0);
    chk("R5 other bank keeps", {31'b0, irq}, 32'd1);
    rd(3);
    chk("R5 other bank keeps", {31'b0, irq}, 32'd1);
    rd(2);
    chk("R5 own bank clears", {31'b0, irq}, 32'd0);

    // R3 falling change
    status[0] = 1'b0;
    tick();
    chk("R3 falling change", {31'b0, irq}, 32'd1);
    rd(0);
    chk("R5 clear bank0", {31'b0, irq}, 32'd0);

    // R6 trigger on the clearing edge
    status[9] = 1'b1;
    tick();
    status[12] = 1'b1;
    rd(1);
    chk("R6 set wins over clear", {31'b0, irq}, 32'd1);
    rd(1);
    chk("R6 later clear", {31'b0, irq}, 32'd0);

    // R7 masked change sets nothing
    mask[30] = 1'b0;
    status[30] = ~status[30];
    tick();
    chk("R7 masked no irq", {31'b0, irq}, 32'd0);
    mask[30] = 1'b1;
    tick();
    chk("R7 masked change left no flag", {31'b0, irq}, 32'd0);
    // pending flag survives masking
    status[5] = ~status[5];
    tick();
    chk("R7 set before mask", {31'b0, irq}, 32'd1);
    mask[5] = 1'b0;
    tick();
    chk("R7 masked flag hidden", {31'b0, irq}, 32'd0);
    mask[5] = 1'b1;
    tick();
    chk("R7 flag kept under mask", {31'b0, irq}, 32'd1);
    rd(0);
    chk("R7 cleared by read", {31'b0, irq}, 32'd0);

    // R9 two-bit field in bank 1 bits [9:8]
    status[9:8] = 2'b01;
    tick();
    rd(1);
    status[9:8] = 2'b10;
    tick();
    chk("R9 field value change", {31'b0, irq}, 32'd1);
    rd(1);
    status[9:8] = 2'b00;
    tick();
    chk("R9 field to 00", {31'b0, irq}, 32'd1);
    rd(1);
    chk("R9 cleared", {31'b0, irq}, 32'd0);

    // mixed random traffic, compared cycle by cycle
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) status = status ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) mask = $urandom;
      rd_stb = ($urandom_range(0, 2) == 0);
      rd_idx = 2'($urandom_range(0, 3));
      tick();
    end
    rd_stb = 1'b0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule